// File: doc/BRIEF.md
# Conditional Operation Unit

This unit executes a family of zero/nonzero conditional integer operations on 16-bit words. On each valid cycle it receives an operation code, a condition word, one or two source words, the current value of the destination and the current top of the small stack. One clock cycle later it presents either a destination write (enable plus value) or a small-stack push (enable plus value).

There are six kinds of operation: conditional copy, conditional add, conditional negate, conditional bitwise NOT, select driven by the stack top, and select with push. Each kind has two polarities. One acts when its condition word is zero and the other acts when it is nonzero. Operand fetch, any addressing side effects and the stack itself stay outside the unit. Those side effects happen whatever the condition turns out to be, so the unit never suppresses its inputs. It only decides what is written back.

The operation code is 4 bits. Bits [3:1] select the kind: 0 copy, 1 add, 2 negate, 3 NOT, 4 stack-top select, 5 select-and-push. Bit [0] selects the polarity: 1 means the condition holds when the condition word is zero, and 0 means it holds when the word is nonzero.

Top module: `cond_op_unit`

## Requirements
- R1: The condition holds when op_code[0] is 1 and the condition word is zero, or when op_code[0] is 0 and the condition word is nonzero. The condition word is `src0`, except for kind 4, where it is `stk_top`.
- R2: For kind 0 (copy), when the condition holds, `wr_en` is 1 and `wr_data` equals `src1`.
- R3: For kind 1 (add), when the condition holds, `wr_en` is 1 and `wr_data` equals `dst_in + src1` modulo 2^16. No overflow is flagged.
- R4: For kind 2 (negate), when the condition holds, `wr_en` is 1 and `wr_data` equals the two's complement of `src1` modulo 2^16.
- R5: For kind 3 (NOT), when the condition holds, `wr_en` is 1 and `wr_data` equals the bitwise inverse of `src1`.
- R6: For kinds 0 to 3, when the condition fails, `wr_en` is 0 and `wr_data` equals `dst_in` (the destination keeps its value). `push_en` is 0.
- R7: For kind 4 (stack-top select), `wr_en` is 1. `wr_data` equals `src1` when the condition holds and `src0` otherwise. `push_en` is 0.
- R8: For kind 5 (select and push), `push_en` is 1 and `wr_en` is 0. `push_data` equals `src1` when the condition holds and `dst_in` otherwise.
- R9: In the cycle after an idle input (`in_valid` 0) or an unused code (12 to 15), both `wr_en` and `push_en` are 0. `wr_en` and `push_en` are never 1 together.
- R10: Results appear exactly one clock edge after the valid input. While reset is applied, both enables and both data outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Operation present this cycle |
| op_code | input | 4 | Kind in [3:1], zero-polarity flag in [0] |
| src0 | input | 16 | First operand; condition word for most kinds |
| src1 | input | 16 | Second operand |
| dst_in | input | 16 | Current destination value |
| stk_top | input | 16 | Current top of the small stack |
| wr_en | output | 1 | Destination write enable |
| wr_data | output | 16 | Destination write value |
| push_en | output | 1 | Small-stack push request |
| push_data | output | 16 | Value to push |

## Verification
Every result is due one rising edge after the inputs that produced it. The bench drives inputs on the falling edge and samples the outputs 1 ns after the next rising edge. This keeps each comparison inside the cycle that follows the stimulus and before the next inputs arrive. The sweep covers all 16 codes against a grid of condition, source, destination and stack-top words, including the zero, one, all-ones and sign-boundary values. Idle cycles are interleaved so the bench can confirm that the enables drop in the very next cycle.

// File: rtl/cond_op_pkg.sv
package cond_op_pkg;

  localparam int OPC_W  = 4;
  localparam int KIND_W = OPC_W - 1;

  typedef enum logic [KIND_W-1:0] {
    K_COPY    = 3'd0,
    K_ADD     = 3'd1,
    K_NEG     = 3'd2,
    K_NOT     = 3'd3,
    K_SELTOS  = 3'd4,
    K_SELPUSH = 3'd5,
    K_RSV6    = 3'd6,
    K_RSV7    = 3'd7
  } cop_kind_e;

  function automatic logic kind_is_legal(input cop_kind_e k);
    return (k != K_RSV6) && (k != K_RSV7);
  endfunction

  function automatic logic kind_writes_dst(input cop_kind_e k);
    return (k == K_COPY) || (k == K_ADD) || (k == K_NEG) ||
           (k == K_NOT) || (k == K_SELTOS);
  endfunction

endpackage

// File: rtl/cond_eval.sv
module cond_eval
  import cond_op_pkg::*;
#(
  parameter int W = 16
) (
  input  cop_kind_e      kind,
  input  logic           zero_form,
  input  logic [W-1:0]   src0,
  input  logic [W-1:0]   stk_top,
  output logic           cond_true
);

  logic [W-1:0] cond_word;
  logic         is_zero;

  always_comb begin
    cond_word = (kind == K_SELTOS) ? stk_top : src0;
    is_zero   = (cond_word == '0);
    cond_true = zero_form ? is_zero : !is_zero;
  end

endmodule

// File: rtl/cond_alu.sv
module cond_alu
  import cond_op_pkg::*;
#(
  parameter int W = 16
) (
  input  cop_kind_e      kind,
  input  logic [W-1:0]   src0,
  input  logic [W-1:0]   src1,
  input  logic [W-1:0]   dst_in,
  output logic [W-1:0]   res_hold,
  output logic [W-1:0]   res_act
);

  logic [W-1:0] sum_w;
  logic [W-1:0] inv_w;
  logic [W-1:0] neg_w;

  always_comb begin
    sum_w = dst_in + src1;
    inv_w = ~src1;
    neg_w = inv_w + W'(1);
  end

  always_comb begin
    res_act  = '0;
    res_hold = dst_in;
    unique case (kind)
      K_COPY:    res_act = src1;
      K_ADD:     res_act = sum_w;
      K_NEG:     res_act = neg_w;
      K_NOT:     res_act = inv_w;
      K_SELTOS:  begin res_act = src1; res_hold = src0;   end
      K_SELPUSH: begin res_act = src1; res_hold = dst_in; end
      default:   begin res_act = '0;   res_hold = dst_in; end
    endcase
  end

endmodule

// File: rtl/cond_route.sv
module cond_route
  import cond_op_pkg::*;
#(
  parameter int W = 16
) (
  input  logic           valid,
  input  cop_kind_e      kind,
  input  logic           cond_true,
  input  logic [W-1:0]   res_hold,
  input  logic [W-1:0]   res_act,
  output logic           wr_en_d,
  output logic [W-1:0]   wr_data_d,
  output logic           push_en_d,
  output logic [W-1:0]   push_data_d
);

  logic [W-1:0] chosen;
  logic         legal;
  logic         to_dst;
  logic         to_stk;

  always_comb begin
    chosen = cond_true ? res_act : res_hold;
    legal  = valid && kind_is_legal(kind);
    to_dst = legal && kind_writes_dst(kind);
    to_stk = legal && (kind == K_SELPUSH);

    wr_en_d     = 1'b0;
    wr_data_d   = res_hold;
    push_en_d   = 1'b0;
    push_data_d = '0;

    if (to_dst) begin
      wr_en_d   = (kind == K_SELTOS) ? 1'b1 : cond_true;
      wr_data_d = chosen;
    end
    if (to_stk) begin
      push_en_d   = 1'b1;
      push_data_d = chosen;
    end
  end

endmodule

// File: rtl/cond_op_unit.sv
module cond_op_unit
  import cond_op_pkg::*;
#(
  parameter int W       = 16,
  parameter int SYNC_FF = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [OPC_W-1:0]     op_code,
  input  logic [W-1:0]         src0,
  input  logic [W-1:0]         src1,
  input  logic [W-1:0]         dst_in,
  input  logic [W-1:0]         stk_top,
  output logic                 wr_en,
  output logic [W-1:0]         wr_data,
  output logic                 push_en,
  output logic [W-1:0]         push_data
);

  // reset: asserted at once, released after SYNC_FF clock edges
  logic [SYNC_FF-1:0] rst_pipe;
  logic               rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_FF-2:0], 1'b1};
  end
  assign rst_int_n = rst_pipe[SYNC_FF-1];

  // decode
  cop_kind_e kind;
  logic      zero_form;
  assign kind      = cop_kind_e'(op_code[OPC_W-1:1]);
  assign zero_form = op_code[0];

  logic         cond_true;
  logic [W-1:0] res_hold, res_act;
  logic         wr_en_d, push_en_d;
  logic [W-1:0] wr_data_d, push_data_d;

  cond_eval #(.W(W)) u_eval (
    .kind      (kind),
    .zero_form (zero_form),
    .src0      (src0),
    .stk_top   (stk_top),
    .cond_true (cond_true)
  );

  cond_alu #(.W(W)) u_alu (
    .kind     (kind),
    .src0     (src0),
    .src1     (src1),
    .dst_in   (dst_in),
    .res_hold (res_hold),
    .res_act  (res_act)
  );

  cond_route #(.W(W)) u_route (
    .valid       (in_valid),
    .kind        (kind),
    .cond_true   (cond_true),
    .res_hold    (res_hold),
    .res_act     (res_act),
    .wr_en_d     (wr_en_d),
    .wr_data_d   (wr_data_d),
    .push_en_d   (push_en_d),
    .push_data_d (push_data_d)
  );

  // output stage: next-state then register
  logic         wr_en_n, push_en_n;
  logic [W-1:0] wr_data_n, push_data_n;
  logic         data_ce;

  always_comb begin
    data_ce     = in_valid;
    wr_en_n     = wr_en_d;
    push_en_n   = push_en_d;
    wr_data_n   = data_ce ? wr_data_d   : wr_data;
    push_data_n = data_ce ? push_data_d : push_data;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      wr_en     <= 1'b0;
      push_en   <= 1'b0;
      wr_data   <= '0;
      push_data <= '0;
    end else begin
      wr_en     <= wr_en_n;
      push_en   <= push_en_n;
      wr_data   <= wr_data_n;
      push_data <= push_data_n;
    end
  end

  // assertions
  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(wr_en && push_en));

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_int_n)
    !in_valid |=> (!wr_en && !push_en));

  a_r3_add_wraps: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_valid && kind == K_ADD && cond_true) |=>
      (wr_en && wr_data == W'($past(dst_in) + $past(src1))));

  a_r6_hold_dst: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_valid && kind_is_legal(kind) && kind != K_SELTOS &&
     kind != K_SELPUSH && !cond_true) |=>
      (!wr_en && wr_data == $past(dst_in)));

  a_r8_push_pick: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_valid && kind == K_SELPUSH) |=>
      (push_en && !wr_en &&
       (push_data == $past(src1) || push_data == $past(dst_in))));

  a_r7_sel_always_writes: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_valid && kind == K_SELTOS) |=> (wr_en && !push_en));

endmodule

// File: tb/tb_cond_op_unit.sv
`timescale 1ns/1ps
module tb_cond_op_unit;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [3:0]   op_code;
  logic [W-1:0] src0, src1, dst_in, stk_top;
  logic         wr_en, push_en;
  logic [W-1:0] wr_data, push_data;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  cond_op_unit #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_code(op_code),
    .src0(src0), .src1(src1), .dst_in(dst_in), .stk_top(stk_top),
    .wr_en(wr_en), .wr_data(wr_data), .push_en(push_en), .push_data(push_data)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h (op=%0d s0=%h s1=%h d=%h t=%h)",
               req, act, exp, op_code, src0, src1, dst_in, stk_top);
    end
  endtask

  function automatic string tag_of(input logic [2:0] k);
    case (k)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R7";
      3'd5: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic run_one(input logic [3:0] opc, input logic [W-1:0] a, b, d, t);
    logic [2:0]   k;
    logic         c;
    logic [W-1:0] cw;
    logic         e_we, e_pe;
    logic [W-1:0] e_wd, e_pd;
    string        tg;
    k  = opc[3:1];
    cw = (k == 3'd4) ? t : a;
    c  = opc[0] ? (cw == '0) : (cw != '0);   // R1
    e_we = 1'b0; e_pe = 1'b0; e_wd = d; e_pd = '0;
    case (k)
      3'd0: begin e_we = c; e_wd = c ? b : d; end
      3'd1: begin e_we = c; e_wd = c ? W'(d + b) : d; end
      3'd2: begin e_we = c; e_wd = c ? W'(0 - b) : d; end
      3'd3: begin e_we = c; e_wd = c ? ~b : d; end
      3'd4: begin e_we = 1'b1; e_wd = c ? b : a; end
      3'd5: begin e_pe = 1'b1; e_pd = c ? b : d; end
      default: ;
    endcase
    tg = (k <= 3'd3 && !c) ? "R6" : tag_of(k);
    @(negedge clk);
    in_valid = 1'b1; op_code = opc; src0 = a; src1 = b; dst_in = d; stk_top = t;
    @(posedge clk); #1;   // R10: one edge of latency
    chk({tg, "/R1 wr_en"},   W'(wr_en),   W'(e_we));
    chk({tg, "/R1 push_en"}, W'(push_en), W'(e_pe));
    if (k <= 3'd4) chk({tg, " wr_data"},   wr_data,   e_wd);
    if (k == 3'd5) chk({tg, " push_data"}, push_data, e_pd);
  endtask

  task automatic idle_one();
    @(negedge clk);
    in_valid = 1'b0; op_code = 4'd0; src0 = '1; src1 = '1; dst_in = '1; stk_top = '1;
    @(posedge clk); #1;
    chk("R9 idle wr_en",   W'(wr_en),   '0);
    chk("R9 idle push_en", W'(push_en), '0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R10 watchdog expired actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [W-1:0] cvals [6];
    logic [W-1:0] bvals [4];
    logic [W-1:0] dvals [3];
    cvals = '{16'h0000, 16'h0001, 16'hFFFF, 16'h8000, 16'h7FFF, 16'h1234};
    bvals = '{16'h0000, 16'h0001, 16'h8000, 16'hA5C3};
    dvals = '{16'h0000, 16'hFFFF, 16'h7FFF};

    rst_n = 1'b0; in_valid = 1'b0; op_code = '0;
    src0 = '0; src1 = '0; dst_in = '0; stk_top = '0;
    repeat (3) @(posedge clk);
    in_valid = 1'b1; op_code = 4'd2; src1 = 16'h5555;   // active input during reset
    @(posedge clk); #1;
    chk("R10 reset wr_en",     W'(wr_en),   '0);
    chk("R10 reset push_en",   W'(push_en), '0);
    chk("R10 reset wr_data",   wr_data,     '0);
    chk("R10 reset push_data", push_data,   '0);
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R3 wrap corner
    run_one(4'b0010, 16'h0001, 16'h0001, 16'hFFFF, 16'h0);
    // R4 negate of most negative value
    run_one(4'b0100, 16'h0001, 16'h8000, 16'h0000, 16'h0);

    for (int opc = 0; opc < 16; opc++) begin
      for (int ci = 0; ci < 6; ci++) begin
        for (int bi = 0; bi < 4; bi++) begin
          for (int di = 0; di < 3; di++) begin
            run_one(4'(opc), cvals[ci], bvals[bi], dvals[di], cvals[(ci + bi + di) % 6]);
          end
        end
        idle_one();
      end
    end

    // R7 stack-top condition independent of src0
    run_one(4'b1001, 16'h0000, 16'h1111, 16'h2222, 16'h0000);
    run_one(4'b1001, 16'h0000, 16'h1111, 16'h2222, 16'h0003);
    run_one(4'b1000, 16'h0000, 16'h1111, 16'h2222, 16'h0003);
    idle_one();

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule